// File: doc/BRIEF.md
# Banked Nibble Data Memory

This block is the 4-bit data store of a small microcontroller core. It serves one read/write port with a 7-bit address and a 4-bit data word. Writes take effect at the rising clock edge; reads are combinational from the address. Every access is decoded to one of three destinations:
- a RAM word private to the selected bank;
- a system-register window that is the same in every bank;
- a port or peripheral register held outside the block and reached through an external register interface.

Three banks of 128 nibbles are provided. The bank in use is chosen by a bank-select register that lives inside the shared system window, so the core switches banks with an ordinary store. The core also sees the current bank number directly, along with the 12-bit value of the three address-register nibbles.

Top module: `nib_bank_mem`

## Requirements
- R1: Each of the three banks holds 128 independent 4-bit RAM words. A write to a RAM address lands at the clock edge, is read back combinationally, and does not disturb the same address in another bank.
- R2: Addresses 74H to 7FH reach the same registers whatever bank is selected. They are never routed to the external interface.
- R3: The bank-select register sits at 79H and holds 0, 1 or 2. Writing 3 or more stores 0. It reads back as its value zero-extended to 4 bits, and `curBank` shows it at all times.
- R4: The address register occupies 75H, 76H and 77H. Each nibble is readable and writable. `addrReg` carries them with 75H in bits 11:8, 76H in bits 7:4 and 77H in bits 3:0.
- R5: The two status nibbles at 7EH and 7FH are readable and writable.
- R6: In banks 0 and 1, addresses 70H to 73H assert `portSel` and return `extRdData`, with `extBank` giving the bank. In bank 2 these addresses are ordinary RAM.
- R7: In bank 1, addresses 50H to 6FH assert `perSel` and return `extRdData`. In banks 0 and 2 these addresses are ordinary RAM.
- R8: Addresses 74H, 78H and 7AH to 7DH read as 0, and writes to them change nothing.
- R9: Reset clears the bank-select register, the address register and the status nibbles to 0.
- R10: A write to the bank-select register changes the decode from the very next cycle onward.
- R11: `extWrEn` is high only when `wrEn` is high and the address is routed externally. `extWrData` and `extAddr` follow the port inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 7 | Access address |
| wrEn | input | 1 | Write strobe for the current access |
| wrData | input | 4 | Write data |
| rdData | output | 4 | Combinational read data |
| extRdData | input | 4 | Read data returned by the external port/peripheral registers |
| portSel | output | 1 | Access targets a port register |
| perSel | output | 1 | Access targets a peripheral control register |
| extWrEn | output | 1 | Write strobe toward the external registers |
| extAddr | output | 7 | Address toward the external registers |
| extBank | output | 2 | Bank of the external access |
| extWrData | output | 4 | Write data toward the external registers |
| curBank | output | 2 | Current bank-select value |
| addrReg | output | 12 | Address-register nibbles, 75H most significant |

## Verification
The assertions take the address and write strobe as settled for the whole cycle before the edge. They also assume that `extRdData` is driven by an external model that answers only while `portSel` or `perSel` is high. The stimulus therefore changes inputs only at the falling edge. It models the external registers as a pure function of `extBank` and `extAddr`. It never reads a RAM word before writing it, because RAM contents after reset are undefined.

// File: rtl/nib_mem_pkg.sv
package nib_mem_pkg;
  localparam int DATA_W    = 4;
  localparam int ADDR_W    = 7;
  localparam int NUM_BANKS = 3;
  localparam int BANK_W    = 2;
  localparam int DEPTH     = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] SYS_LO   = 7'h74;
  localparam logic [ADDR_W-1:0] AR_HI    = 7'h75;
  localparam logic [ADDR_W-1:0] AR_MID   = 7'h76;
  localparam logic [ADDR_W-1:0] AR_LO    = 7'h77;
  localparam logic [ADDR_W-1:0] BANK_SEL = 7'h79;
  localparam logic [ADDR_W-1:0] PSW_HI   = 7'h7E;
  localparam logic [ADDR_W-1:0] PSW_LO   = 7'h7F;
  localparam logic [ADDR_W-1:0] PORT_LO  = 7'h70;
  localparam logic [ADDR_W-1:0] PORT_HI  = 7'h73;
  localparam logic [ADDR_W-1:0] PERI_LO  = 7'h50;
  localparam logic [ADDR_W-1:0] PERI_HI  = 7'h6F;

  typedef enum logic [1:0] {
    REG_RAM  = 2'd0,
    REG_SYS  = 2'd1,
    REG_PORT = 2'd2,
    REG_PERI = 2'd3
  } regionE;

  typedef struct packed {
    regionE region;
    logic   ramWe;
    logic   sysWe;
    logic   extWe;
  } strobeT;
endpackage

// File: rtl/nib_mem_ctrl.sv
module nib_mem_ctrl
  import nib_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [BANK_W-1:0] curBank,
  output strobeT            strb,
  output logic              portSel,
  output logic              perSel
);
  logic inSys, inPort, inPeri;

  always_comb begin
    inSys  = (addr >= SYS_LO);
    inPort = !inSys && (addr >= PORT_LO) && (addr <= PORT_HI) &&
             (curBank != BANK_W'(2));
    inPeri = (addr >= PERI_LO) && (addr <= PERI_HI) &&
             (curBank == BANK_W'(1));
  end

  always_comb begin
    strb = '0;
    if (inSys)       strb.region = REG_SYS;
    else if (inPort) strb.region = REG_PORT;
    else if (inPeri) strb.region = REG_PERI;
    else             strb.region = REG_RAM;
    strb.ramWe = wrEn && (strb.region == REG_RAM);
    strb.sysWe = wrEn && (strb.region == REG_SYS);
    strb.extWe = wrEn && ((strb.region == REG_PORT) || (strb.region == REG_PERI));
  end

  assign portSel = (strb.region == REG_PORT);
  assign perSel  = (strb.region == REG_PERI);

  AST_SHARED_NOT_EXT: assert property (@(posedge clk) disable iff (!rstN)
    (addr >= SYS_LO) |-> (!portSel && !perSel)); // R2
  AST_PORT_BANK: assert property (@(posedge clk) disable iff (!rstN)
    portSel |-> (curBank != BANK_W'(2))); // R6
  AST_PERI_BANK: assert property (@(posedge clk) disable iff (!rstN)
    perSel |-> (curBank == BANK_W'(1))); // R7
  AST_EXT_WE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    strb.extWe |-> (wrEn && (portSel || perSel))); // R11
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ramWe, strb.sysWe, strb.extWe})); // R1
endmodule

// File: rtl/nib_mem_dpath.sv
module nib_mem_dpath
  import nib_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] extRdData,
  input  strobeT            strb,
  output logic [DATA_W-1:0] rdData,
  output logic [BANK_W-1:0] curBank,
  output logic [3*DATA_W-1:0] addrReg
);
  localparam int WORDS = NUM_BANKS * DEPTH;
  localparam int IDX_W = $clog2(WORDS);

  logic [DATA_W-1:0] ram [WORDS];
  logic [BANK_W-1:0] bankQ;
  logic [DATA_W-1:0] arQ [3];
  logic [DATA_W-1:0] pswQ [2];
  logic [IDX_W-1:0]  ramIdx;
  logic [DATA_W-1:0] sysRd;

  assign ramIdx = IDX_W'(bankQ) * IDX_W'(DEPTH) + IDX_W'(addr);

  always_ff @(posedge clk) begin
    if (strb.ramWe) ram[ramIdx] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ <= '0;
      for (int i = 0; i < 3; i++) arQ[i] <= '0;
      for (int i = 0; i < 2; i++) pswQ[i] <= '0;
    end else if (strb.sysWe) begin
      case (addr)
        AR_HI:    arQ[0]  <= wrData;
        AR_MID:   arQ[1]  <= wrData;
        AR_LO:    arQ[2]  <= wrData;
        PSW_HI:   pswQ[0] <= wrData;
        PSW_LO:   pswQ[1] <= wrData;
        BANK_SEL: bankQ   <= (int'(wrData) < NUM_BANKS) ? wrData[BANK_W-1:0] : '0;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      AR_HI:    sysRd = arQ[0];
      AR_MID:   sysRd = arQ[1];
      AR_LO:    sysRd = arQ[2];
      PSW_HI:   sysRd = pswQ[0];
      PSW_LO:   sysRd = pswQ[1];
      BANK_SEL: sysRd = DATA_W'(bankQ);
      default:  sysRd = '0;
    endcase
  end

  always_comb begin
    case (strb.region)
      REG_RAM: rdData = ram[ramIdx];
      REG_SYS: rdData = sysRd;
      default: rdData = extRdData;
    endcase
  end

  assign curBank = bankQ;
  assign addrReg = {arQ[0], arQ[1], arQ[2]};

  AST_BANK_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    int'(curBank) < NUM_BANKS); // R3
  AST_BANK_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sysWe && addr == BANK_SEL && wrData >= DATA_W'(NUM_BANKS)) |=> (curBank == '0)); // R3
  AST_AR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.sysWe && addr >= AR_HI && addr <= AR_LO) |=> $stable(addrReg)); // R4
  AST_RSVD_READ: assert property (@(posedge clk) disable iff (!rstN)
    (strb.region == REG_SYS && (addr == SYS_LO || addr == 7'h78 ||
     (addr >= 7'h7A && addr <= 7'h7D))) |-> (rdData == '0)); // R8
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.sysWe && addr == BANK_SEL) |=> $stable(curBank)); // R10
endmodule

// File: rtl/nib_bank_mem.sv
module nib_bank_mem
  import nib_mem_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [DATA_W-1:0]   extRdData,
  output logic                portSel,
  output logic                perSel,
  output logic                extWrEn,
  output logic [ADDR_W-1:0]   extAddr,
  output logic [BANK_W-1:0]   extBank,
  output logic [DATA_W-1:0]   extWrData,
  output logic [BANK_W-1:0]   curBank,
  output logic [3*DATA_W-1:0] addrReg
);
  strobeT strb;

  nib_mem_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .curBank(curBank),
    .strb(strb), .portSel(portSel), .perSel(perSel)
  );

  nib_mem_dpath i_dpath (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .extRdData(extRdData),
    .strb(strb), .rdData(rdData), .curBank(curBank), .addrReg(addrReg)
  );

  assign extWrEn   = strb.extWe;
  assign extAddr   = addr;
  assign extBank   = curBank;
  assign extWrData = wrData;
endmodule

// File: tb/test_nib_bank_mem.sv
module test_nib_bank_mem;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrData = '0;
  logic [3:0]  rdData, extRdData, extWrData;
  logic        portSel, perSel, extWrEn;
  logic [6:0]  extAddr;
  logic [1:0]  extBank, curBank;
  logic [11:0] addrReg;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  // External register model: ports return {bank, addr[1:0]}, peripherals ~addr[3:0]
  always_comb begin
    if (portSel)     extRdData = {extBank, extAddr[1:0]};
    else if (perSel) extRdData = ~extAddr[3:0];
    else             extRdData = 4'h0;
  end

  nib_bank_mem i_nib_bank_mem (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .extRdData(extRdData), .portSel(portSel), .perSel(perSel),
    .extWrEn(extWrEn), .extAddr(extAddr), .extBank(extBank),
    .extWrData(extWrData), .curBank(curBank), .addrReg(addrReg)
  );

  // vector: {write, addr[6:0], data[3:0], expected[3:0], req[3:0]}
  localparam int NV = 40;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 7'h00, 4'h5, 4'h0, 4'd1},  // R1 write bank0
    {1'b0, 7'h00, 4'h0, 4'h5, 4'd1},  // R1
    {1'b1, 7'h79, 4'h2, 4'h0, 4'd3},  // R3 select bank2
    {1'b1, 7'h00, 4'hA, 4'h0, 4'd1},
    {1'b0, 7'h00, 4'h0, 4'hA, 4'd1},  // R1
    {1'b0, 7'h79, 4'h0, 4'h2, 4'd3},  // R3
    {1'b1, 7'h79, 4'h0, 4'h0, 4'd3},
    {1'b0, 7'h00, 4'h0, 4'h5, 4'd1},  // R1 isolation
    {1'b1, 7'h75, 4'h1, 4'h0, 4'd4},
    {1'b1, 7'h76, 4'h2, 4'h0, 4'd4},
    {1'b1, 7'h77, 4'h3, 4'h0, 4'd4},
    {1'b0, 7'h76, 4'h0, 4'h2, 4'd4},  // R4
    {1'b1, 7'h7E, 4'h9, 4'h0, 4'd5},
    {1'b0, 7'h7E, 4'h0, 4'h9, 4'd5},  // R5
    {1'b1, 7'h7F, 4'h6, 4'h0, 4'd5},
    {1'b0, 7'h7F, 4'h0, 4'h6, 4'd5},  // R5
    {1'b1, 7'h78, 4'hF, 4'h0, 4'd8},
    {1'b0, 7'h78, 4'h0, 4'h0, 4'd8},  // R8
    {1'b1, 7'h7C, 4'h7, 4'h0, 4'd8},
    {1'b0, 7'h7C, 4'h0, 4'h0, 4'd8},  // R8
    {1'b0, 7'h74, 4'h0, 4'h0, 4'd8},  // R8
    {1'b0, 7'h72, 4'h0, 4'h2, 4'd6},  // R6 bank0 port
    {1'b1, 7'h55, 4'hC, 4'h0, 4'd7},
    {1'b0, 7'h55, 4'h0, 4'hC, 4'd7},  // R7 bank0 RAM
    {1'b1, 7'h79, 4'h1, 4'h0, 4'd3},
    {1'b0, 7'h72, 4'h0, 4'h6, 4'd6},  // R6 bank1 port
    {1'b0, 7'h55, 4'h0, 4'hA, 4'd7},  // R7 bank1 peripheral
    {1'b1, 7'h79, 4'h2, 4'h0, 4'd3},
    {1'b1, 7'h55, 4'h3, 4'h0, 4'd7},
    {1'b0, 7'h55, 4'h0, 4'h3, 4'd7},  // R7 bank2 RAM
    {1'b1, 7'h72, 4'h4, 4'h0, 4'd6},
    {1'b0, 7'h72, 4'h0, 4'h4, 4'd6},  // R6 bank2 RAM
    {1'b1, 7'h7E, 4'h4, 4'h0, 4'd2},
    {1'b1, 7'h79, 4'h0, 4'h0, 4'd3},
    {1'b0, 7'h7E, 4'h0, 4'h4, 4'd2},  // R2 shared window
    {1'b0, 7'h55, 4'h0, 4'hC, 4'd1},  // R1 bank0 word kept
    {1'b1, 7'h79, 4'h3, 4'h0, 4'd3},
    {1'b0, 7'h79, 4'h0, 4'h0, 4'd3},  // R3 clamp of 3
    {1'b1, 7'h79, 4'hF, 4'h0, 4'd3},
    {1'b0, 7'h79, 4'h0, 4'h0, 4'd3}   // R3 clamp of F
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic access(input logic w, input logic [6:0] a, input logic [3:0] d);
    @(negedge clk);
    wrEn = w; addr = a; wrData = d;
    #2;
  endtask

  initial begin
    #20000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9 reset state
    access(1'b0, 7'h79, 4'h0); check("R9", 16'(rdData), 16'h0);
    check("R9", 16'(curBank), 16'h0);
    check("R9", 16'(addrReg), 16'h0);
    access(1'b0, 7'h7F, 4'h0); check("R9", 16'(rdData), 16'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][19], VEC[i][18:12], VEC[i][11:8]);
      if (!VEC[i][19])
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), 16'(rdData), 16'(VEC[i][7:4]));
    end

    // R4 output ordering: 75H=1, 76H=2, 77H=3
    access(1'b0, 7'h00, 4'h0); check("R4", 16'(addrReg), 16'h123);
    // R8 writes ignored: address register and status unchanged
    check("R8", 16'(addrReg), 16'h123);
    // R11 external strobe on port write in bank0
    access(1'b1, 7'h71, 4'h9);
    check("R11", 16'({extWrEn, portSel, extWrData}), 16'h39);
    check("R11", 16'({extBank, extAddr}), 16'h071);
    access(1'b1, 7'h10, 4'h7);
    check("R11", 16'({extWrEn, portSel, perSel}), 16'h0);
    // R10 bank change takes effect on the next access
    access(1'b1, 7'h79, 4'h1);
    check("R10", 16'({perSel, curBank}), 16'h0);
    access(1'b0, 7'h60, 4'h0);
    check("R10", 16'({perSel, curBank}), 16'h5);
    check("R10", 16'(rdData), 16'hF);
    // R2 shared window in bank1 not external
    access(1'b1, 7'h7F, 4'hB);
    check("R2", 16'({extWrEn, portSel, perSel}), 16'h0);
    access(1'b0, 7'h7F, 4'h0); check("R2", 16'(rdData), 16'hB);
    // R9 reset mid-run clears registers
    wrEn = 1'b0;
    rstN = 1'b0; #3; rstN = 1'b1;
    access(1'b0, 7'h7F, 4'h0); check("R9", 16'(rdData), 16'h0);
    check("R9", 16'({curBank, addrReg}), 16'h0);
    finished = 1'b1;
    report();
  end
endmodule